// File: doc/BRIEF.md
# Load/Store Size Formatting Unit

This unit sits on the data path between a 32-bit core and a byte-addressed memory port. A single control code selects both the access width (byte, halfword or word) and, for loads, whether the narrow value is zero- or sign-extended. Only five codes are legal: 0x00 for a word, 0x01 for an unsigned byte, 0x11 for a signed byte, 0x02 for an unsigned halfword and 0x12 for a signed halfword. Every other code of the 8-bit field is refused.

On a load, the unit picks the addressed lane out of the memory data and extends it to the full register width. On a store, it copies the register data into every lane of the chosen width and raises the byte strobes of the addressed lane. The address either comes from a register operand or, in the immediate form, from the 8-bit operand field itself, zero-extended. Lanes are numbered big-endian: address offset 0 is bits 31..24. An access that is not aligned is steered to the aligned lane that contains it and is not reported as an error. The data path is combinational. A refused code raises a trap flag one cycle after the request.

Top module: `ldst_shaper`

## Requirements
- R1: With code 0x00, a load returns the memory word unchanged on `load_val`, and a store drives `store_data` equal to `store_wdata` with `store_strb` = 4'b1111.
- R2: With code 0x01, a load returns the addressed byte in bits 7..0 with bits 31..8 zero. Offset 0 selects memory bits 31..24, offset 1 selects 23..16, offset 2 selects 15..8 and offset 3 selects 7..0.
- R3: With code 0x11, a load returns the addressed byte, chosen as in R2, with bit 7 copied into bits 31..8.
- R4: With code 0x02, a load returns the addressed halfword in bits 15..0 with bits 31..16 zero. Address bit 1 = 0 selects memory bits 31..16 and address bit 1 = 1 selects bits 15..0.
- R5: With code 0x12, a load returns the addressed halfword, chosen as in R4, with bit 15 copied into bits 31..16.
- R6: For any code other than the five legal ones, `load_we` stays 0 and `store_strb` stays 4'b0000, whether the request is a load or a store.
- R7: `trap_q` is 1 in the cycle after a clock edge that samples `req_valid`=1 with an illegal code, and 0 otherwise. It is 0 out of reset.
- R8: Store strobes follow the access width. Bit k of `store_strb` enables memory bits 8k+7..8k. A byte store enables only the strobe of its lane (offset 0 is bit 3). A halfword store enables 4'b1100 when address bit 1 = 0 and 4'b0011 when it is 1. Codes 0x01 and 0x11 give identical store outputs, and so do 0x02 and 0x12.
- R9: A byte store replicates `store_wdata[7:0]` into all four byte lanes of `store_data`, and a halfword store replicates `store_wdata[15:0]` into both halves.
- R10: With `use_imm`=1, `mem_addr` equals `imm_addr` zero-extended, and the lane is chosen from `imm_addr`. `reg_addr` has no effect. With `use_imm`=0, `mem_addr` equals `reg_addr`.
- R11: A halfword access with address bit 0 set, or a word access with address bits 1..0 non-zero, uses the aligned lane that contains it. It raises no trap, and its load write enable or store strobes are produced as for an aligned access.
- R12: `load_we` is 1 exactly when `req_valid`=1, `req_is_store`=0 and the code is legal. `store_strb` is non-zero only when `req_valid`=1, `req_is_store`=1 and the code is legal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request in this cycle |
| req_is_store | input | 1 | 1 = store, 0 = load |
| ctrl | input | 8 | Combined width and signedness code |
| use_imm | input | 1 | 1 = take the address from `imm_addr` |
| reg_addr | input | ADDR_W | Address from a register operand |
| imm_addr | input | IMM_W | Immediate address field |
| load_rdata | input | DATA_W | Data returned by memory |
| store_wdata | input | DATA_W | Register data to be stored |
| mem_addr | output | ADDR_W | Effective address to the memory port |
| load_val | output | DATA_W | Formatted load result |
| load_we | output | 1 | Register write enable for the load result |
| store_data | output | DATA_W | Lane-replicated write data |
| store_strb | output | DATA_W/8 | Byte write strobes |
| trap_q | output | 1 | Registered illegal-control trap |

## Verification
The bench builds the unit with the default 32-bit data path, which gives four byte lanes and two halfword lanes. It narrows `ADDR_W` to 10 so that the immediate sweep and address checks stay small. With that setup the bench can cover every 8-bit control code against every byte offset, for both loads and stores and for two data patterns: one with the sign bits of every lane set and one with them clear. Each unaligned halfword and word offset is checked at every step. A separate sweep covers all 256 immediate address values. It sets the register operand to a different lane each time, so that a wrong address source shows up in both the lane choice and the address sent to memory.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef struct packed {
    logic      legal;
    logic      sext;
    acc_size_e size;
  } acc_ctl_t;

  localparam int unsigned CTRL_W = 8;

  localparam logic [CTRL_W-1:0] CC_WORD  = 8'h00;
  localparam logic [CTRL_W-1:0] CC_UBYTE = 8'h01;
  localparam logic [CTRL_W-1:0] CC_SBYTE = 8'h11;
  localparam logic [CTRL_W-1:0] CC_UHALF = 8'h02;
  localparam logic [CTRL_W-1:0] CC_SHALF = 8'h12;

endpackage

// File: rtl/ldst_decode.sv
module ldst_decode
  import ldst_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrl,
  output acc_ctl_t          ctl
);

  always_comb begin
    ctl = '{legal: 1'b0, sext: 1'b0, size: SZ_WORD};
    unique case (ctrl)
      CC_WORD:  ctl = '{legal: 1'b1, sext: 1'b0, size: SZ_WORD};
      CC_UBYTE: ctl = '{legal: 1'b1, sext: 1'b0, size: SZ_BYTE};
      CC_SBYTE: ctl = '{legal: 1'b1, sext: 1'b1, size: SZ_BYTE};
      CC_UHALF: ctl = '{legal: 1'b1, sext: 1'b0, size: SZ_HALF};
      CC_SHALF: ctl = '{legal: 1'b1, sext: 1'b1, size: SZ_HALF};
      default:  ctl = '{legal: 1'b0, sext: 1'b0, size: SZ_WORD};
    endcase
  end

endmodule

// File: rtl/ldst_load_align.sv
module ldst_load_align
  import ldst_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES  = DATA_W / 8,
  localparam int unsigned HALVES = LANES / 2,
  localparam int unsigned LANE_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] rdata,
  input  logic [LANE_W-1:0] lane,
  input  acc_size_e         size,
  input  logic              sext,
  output logic [DATA_W-1:0] val
);

  logic [7:0]  bytes_be [LANES];
  logic [15:0] halves_be[HALVES];
  logic [7:0]  byte_sel;
  logic [15:0] half_sel;

  // Big-endian lane order: lane 0 is the most significant byte.
  for (genvar i = 0; i < LANES; i++) begin : g_byte
    assign bytes_be[i] = rdata[DATA_W-1-8*i -: 8];
  end
  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign halves_be[h] = rdata[DATA_W-1-16*h -: 16];
  end

  assign byte_sel = bytes_be[lane];
  assign half_sel = halves_be[lane[LANE_W-1:1]];

  always_comb begin
    unique case (size)
      SZ_BYTE: val = {{(DATA_W-8){sext & byte_sel[7]}}, byte_sel};
      SZ_HALF: val = {{(DATA_W-16){sext & half_sel[15]}}, half_sel};
      default: val = rdata;
    endcase
  end

endmodule

// File: rtl/ldst_store_align.sv
module ldst_store_align
  import ldst_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES  = DATA_W / 8,
  localparam int unsigned HALVES = LANES / 2,
  localparam int unsigned LANE_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] wdata_in,
  input  logic [LANE_W-1:0] lane,
  input  acc_size_e         size,
  input  logic              enable,
  output logic [DATA_W-1:0] wdata,
  output logic [LANES-1:0]  strb
);

  always_comb begin
    unique case (size)
      SZ_BYTE: wdata = {LANES{wdata_in[7:0]}};
      SZ_HALF: wdata = {HALVES{wdata_in[15:0]}};
      default: wdata = wdata_in;
    endcase
  end

  // Lane i (big-endian) drives strobe bit LANES-1-i.
  for (genvar i = 0; i < LANES; i++) begin : g_strb
    logic hit;
    always_comb begin
      unique case (size)
        SZ_BYTE: hit = (lane == LANE_W'(i));
        SZ_HALF: hit = (lane[LANE_W-1:1] == (LANE_W-1)'(i / 2));
        default: hit = 1'b1;
      endcase
    end
    assign strb[LANES-1-i] = enable & hit;
  end

endmodule

// File: rtl/ldst_shaper.sv
module ldst_shaper
  import ldst_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IMM_W  = 8,
  localparam int unsigned LANES  = DATA_W / 8,
  localparam int unsigned LANE_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_is_store,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              use_imm,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [IMM_W-1:0]  imm_addr,
  input  logic [DATA_W-1:0] load_rdata,
  input  logic [DATA_W-1:0] store_wdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] load_val,
  output logic              load_we,
  output logic [DATA_W-1:0] store_data,
  output logic [LANES-1:0]  store_strb,
  output logic              trap_q
);

  acc_ctl_t          ctl;
  logic [LANE_W-1:0] lane;
  logic              st_en;
  logic              trap_nxt;
  logic              trap_en;

  ldst_decode u_decode (
    .ctrl (ctrl),
    .ctl  (ctl)
  );

  assign mem_addr = use_imm ? {{(ADDR_W-IMM_W){1'b0}}, imm_addr} : reg_addr;
  assign lane     = mem_addr[LANE_W-1:0];

  ldst_load_align #(.DATA_W(DATA_W)) u_load (
    .rdata (load_rdata),
    .lane  (lane),
    .size  (ctl.size),
    .sext  (ctl.sext),
    .val   (load_val)
  );

  assign load_we = req_valid & ~req_is_store & ctl.legal;
  assign st_en   = req_valid &  req_is_store & ctl.legal;

  ldst_store_align #(.DATA_W(DATA_W)) u_store (
    .wdata_in (store_wdata),
    .lane     (lane),
    .size     (ctl.size),
    .enable   (st_en),
    .wdata    (store_data),
    .strb     (store_strb)
  );

  // Trap flag: next-state and register kept apart.
  always_comb begin
    trap_nxt = req_valid & ~ctl.legal;
    trap_en  = req_valid | trap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_q <= 1'b0;
    end else if (trap_en) begin
      trap_q <= trap_nxt;
    end
  end

endmodule

// File: rtl/ldst_shaper_chk.sv
module ldst_shaper_chk #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_is_store,
  input logic [7:0]        ctrl,
  input logic [DATA_W-1:0] load_val,
  input logic              load_we,
  input logic [LANES-1:0]  store_strb,
  input logic              trap_q
);

  // R12: strobes only for a valid store request
  p_strb_gated_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (store_strb != '0) |-> (req_valid && req_is_store));

  // R12: register write only for a valid load request
  p_we_gated_r12: assert property (@(posedge clk) disable iff (!rst_n)
    load_we |-> (req_valid && !req_is_store));

  // R8: strobe patterns are one byte, one half or the full word
  p_strb_shape_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(store_strb) inside {0, 1, 2, LANES}));

  // R7: a request that produced neither write traps next cycle
  p_trap_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !load_we && store_strb == '0) |=> trap_q);

  // R7: no request, no trap
  p_trap_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !trap_q);

  // R6: a traps follows only a request with no write
  p_trap_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_we || store_strb != '0) |=> !trap_q);

  // R2: unsigned byte load clears the upper bits
  p_zext_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_we && ctrl == 8'h01) |-> (load_val[DATA_W-1:8] == '0));

  // R3: signed byte load replicates bit 7
  p_sext_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_we && ctrl == 8'h11) |-> (load_val[DATA_W-1:8] == {(DATA_W-8){load_val[7]}}));

  // R5: signed halfword load replicates bit 15
  p_sext_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_we && ctrl == 8'h12) |-> (load_val[DATA_W-1:16] == {(DATA_W-16){load_val[15]}}));

endmodule

bind ldst_shaper ldst_shaper_chk #(.DATA_W(DATA_W)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_is_store (req_is_store),
  .ctrl         (ctrl),
  .load_val     (load_val),
  .load_we      (load_we),
  .store_strb   (store_strb),
  .trap_q       (trap_q)
);

// File: tb/test_ldst_shaper.sv
module test_ldst_shaper;

  localparam int ADDR_W = 10;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid, req_is_store, use_imm;
  logic [7:0]        ctrl;
  logic [ADDR_W-1:0] reg_addr;
  logic [7:0]        imm_addr;
  logic [31:0]       load_rdata, store_wdata;
  logic [ADDR_W-1:0] mem_addr;
  logic [31:0]       load_val, store_data;
  logic              load_we, trap_q;
  logic [3:0]        store_strb;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ldst_shaper #(.DATA_W(32), .ADDR_W(ADDR_W), .IMM_W(8)) i_ldst_shaper (
    .clk, .rst_n, .req_valid, .req_is_store, .ctrl, .use_imm, .reg_addr,
    .imm_addr, .load_rdata, .store_wdata, .mem_addr, .load_val, .load_we,
    .store_data, .store_strb, .trap_q
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic bit is_legal(int c);
    return c == 8'h00 || c == 8'h01 || c == 8'h11 || c == 8'h02 || c == 8'h12;
  endfunction

  function automatic string tag_of(int c, int a);
    if (!is_legal(c)) return "R6";
    if ((c == 8'h00 && a != 0) || ((c & 3) == 2 && a % 2 == 1)) return "R11";
    case (c)
      8'h00:   return "R1";
      8'h01:   return "R2";
      8'h11:   return "R3";
      8'h02:   return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic logic [31:0] exp_load(int c, int a, logic [31:0] d);
    logic [31:0] v;
    if ((c & 3) == 1) begin
      v = (d >> (8 * (3 - a))) & 32'hFF;
      if (c == 8'h11 && v > 127) v = v + 32'hFFFF_FF00;
    end else if ((c & 3) == 2) begin
      v = (d >> (16 * (1 - a / 2))) & 32'hFFFF;
      if (c == 8'h12 && v > 32767) v = v + 32'hFFFF_0000;
    end else v = d;
    return v;
  endfunction

  function automatic logic [31:0] exp_sdata(int c, logic [31:0] d);
    if ((c & 3) == 1) return (d & 32'hFF) * 32'h0101_0101;
    if ((c & 3) == 2) return (d & 32'hFFFF) * 32'h0001_0001;
    return d;
  endfunction

  function automatic logic [3:0] exp_strb(int c, int a);
    if ((c & 3) == 1) return 4'(1 << (3 - a));
    if ((c & 3) == 2) return (a < 2) ? 4'hC : 4'h3;
    return 4'hF;
  endfunction

  initial begin
    #100000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: act=%h exp=%h", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats[2];
    pats[0] = 32'h8192_A3F4;
    pats[1] = 32'h7F01_6C35;
    rst_n = 1'b0; req_valid = 0; req_is_store = 0; use_imm = 0;
    ctrl = '0; reg_addr = '0; imm_addr = '0; load_rdata = '0; store_wdata = '0;
    repeat (3) @(posedge clk);
    #1 check("R7", "trap after reset", 32'(trap_q), 0);
    @(negedge clk) rst_n = 1'b1;

    // Sweep every code, direction, offset and pattern.
    for (int c = 0; c < 256; c++) begin
      for (int s = 0; s < 2; s++) begin
        for (int a = 0; a < 4; a++) begin
          for (int p = 0; p < 2; p++) begin
            string t;
            bit lg;
            t  = tag_of(c, a);
            lg = is_legal(c);
            @(negedge clk);
            req_valid = 1; req_is_store = s[0]; ctrl = 8'(c); use_imm = 0;
            reg_addr = ADDR_W'(4 * (c + p) + a);
            load_rdata = pats[p]; store_wdata = pats[1 - p];
            #1;
            if (s == 0) begin
              check(lg ? "R12" : "R6", "load_we", 32'(load_we), 32'(lg));
              check(t, "strb on load", 32'(store_strb), 0);
              if (lg) check(t, "load_val", load_val, exp_load(c, a, pats[p]));
            end else begin
              check(t, "we on store", 32'(load_we), 0);
              check((lg && t != "R11") ? "R8" : t, "strb",
                    32'(store_strb), lg ? 32'(exp_strb(c, a)) : 0);
              if (lg) check(c == 0 ? "R1" : "R9", "store_data", store_data,
                            exp_sdata(c, pats[1 - p]));
            end
            @(posedge clk);
            #1 check(lg ? t : "R7", "trap_q", 32'(trap_q), 32'(!lg));
          end
        end
      end
    end

    // Idle cycles with an illegal code: nothing happens, trap clears.
    @(negedge clk);
    req_valid = 0; ctrl = 8'h33;
    #1;
    check("R12", "idle we", 32'(load_we), 0);
    check("R12", "idle strb", 32'(store_strb), 0);
    @(posedge clk);
    #1 check("R7", "idle trap", 32'(trap_q), 0);

    // Immediate addressing: register operand must not matter.
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      req_valid = 1; req_is_store = 0; ctrl = 8'h01; use_imm = 1;
      imm_addr = 8'(i); reg_addr = ADDR_W'(i + 2) | ADDR_W'(10'h300);
      load_rdata = 32'h1122_3344;
      #1;
      check("R10", "imm mem_addr", 32'(mem_addr), 32'(i));
      check("R10", "imm lane", load_val, exp_load(1, i % 4, 32'h1122_3344));
    end
    @(negedge clk);
    use_imm = 0; reg_addr = ADDR_W'(10'h2B7);
    #1 check("R10", "reg mem_addr", 32'(mem_addr), 32'h2B7);
    @(negedge clk) req_valid = 0;

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule